// File: doc/BRIEF.md
# Plug-and-Play Card Isolation Controller

This block is the card-side sequencer of a legacy expansion-bus plug-and-play scheme. While idle it watches writes to the host address port for a fixed 32-byte unlock pattern. Once unlocked, the card sleeps until the host wakes it with a data value equal to its card select number. A card whose number is still zero then enters a serial contest in which every unnumbered card in the system takes part. The card that is left at the end of the contest is given a number by the host, and from then on it is reached directly by that number.

The card does not store its identity itself. A local processor supplies the 64 identity bits and then 8 check bits, one per contest slot. It learns that a bit is wanted either by polling a status flag or by taking an interrupt. Each contest slot consists of two host reads of the isolation register. The host may space these reads as far apart as it likes. Reads that arrive before the local processor has supplied the bit are left unanswered. The card computes its own checksum over the identity bits and withdraws from the contest if the check bits it is given do not match.

Top module: `pnp_iso_ctrl`

## Requirements
- R1: After reset the card is in wait-for-key, its card select number is 00h, the interrupt is low and host reads are not driven.
- R2: In wait-for-key the unlock pattern is 32 writes to the address port. The first byte is 6Ah, and each later byte is the previous byte k shifted left, with bit 0 set to k[7]^k[5]^k[4]^k[3]. The last matching write moves the card to sleep. A write that does not match restarts the pattern at its first byte.
- R3: A write to the wake register (index 03h) with a value equal to the card select number 00h enters isolation and raises the need flag. A wake with any other value leaves the card asleep.
- R4: The local status register (local address 0) reads as {4'b0, state[1:0], won, need}, with states wait-for-key=0, sleep=1, isolation=2 and configuration=3. A local write to address 0 supplies the slot bit and clears need. The interrupt equals need while bit 0 of local address 1 is set.
- R5: In isolation, with index 01h selected, a slot holding a one drives 55h on its first read and AAh on its second. A slot holding a zero drives nothing. Bits are sent identity bit 0 first, then checksum bit 0 first. A read made before the slot bit arrives is not driven and does not advance the slot.
- R6: A card holding a zero slot bit that sees 55h on the bus at the first read and AAh at the second read drops to sleep. It does not drop if either value differs.
- R7: The expected checksum starts at 6Ah and takes c = {c[0]^c[1]^b, c[7:1]} for each identity bit b. After 72 slots a matching checksum sets won. A mismatch sends the card to sleep.
- R8: After winning, a nonzero write to index 06h stores the card select number and enters configuration. Host reads of index 06h in configuration drive the number, and local address 1 reads it back.
- R9: A card with a nonzero number stays asleep on a wake with 00h and never re-enters isolation.
- R10: Writing a value with bit 1 set to index 02h returns to wait-for-key and keeps the number. In wait-for-key, host reads are never driven and data-port writes have no effect.
- R11: After a new unlock pattern, a wake with the stored nonzero number enters configuration directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr_wr | input | 1 | Host write strobe for the address port |
| host_data_wr | input | 1 | Host write strobe for the write-data port |
| host_rd | input | 1 | Host read strobe for the read-data port |
| host_wdata | input | 8 | Host write data |
| host_bus_in | input | 8 | Value observed on the shared data bus during a read |
| host_rdata | output | 8 | Read data driven by this card |
| host_rdrive | output | 1 | Bus output enable for host_rdata |
| lp_addr | input | 1 | Local processor register select |
| lp_wr | input | 1 | Local processor write strobe |
| lp_wbit | input | 1 | Local processor write bit |
| lp_rdata | output | 8 | Local processor read data |
| lp_irq | output | 1 | Bit-request interrupt to the local processor |

## Verification
The bench builds the block with its default parameters: a 64-bit identity, an 8-bit checksum, a 32-byte unlock pattern, a level interrupt and checksum checking switched on. With these values it runs full 72-slot contests, both won and rejected on the checksum. It also drives competing-card patterns on the bus input to reach the drop-out rule, and makes early reads to confirm that a slow local processor does not move a slot forward. A second unlock after numbering brings the direct-wake path and the exclusion of numbered cards within reach.

// File: rtl/pnp_iso_pkg.sv
package pnp_iso_pkg;

   typedef enum logic [1:0] {
      ST_WAIT_KEY = 2'd0,
      ST_SLEEP    = 2'd1,
      ST_ISOLATE  = 2'd2,
      ST_CONFIG   = 2'd3
   } card_state_e;

   localparam logic [7:0] ISO_FIRST  = 8'h55;
   localparam logic [7:0] ISO_SECOND = 8'hAA;

   // next byte of the unlock pattern
   function automatic logic [7:0] key_step(input logic [7:0] k);
      return {k[6:0], k[7] ^ k[5] ^ k[4] ^ k[3]};
   endfunction

   // checksum register update for one identity bit
   function automatic logic [7:0] chk_step(input logic [7:0] c, input logic b);
      return {c[0] ^ c[1] ^ b, c[7:1]};
   endfunction

endpackage

// File: rtl/pnp_key_detect.sv
module pnp_key_detect
   import pnp_iso_pkg::*;
#(
   parameter int         KEY_LEN  = 32,
   parameter logic [7:0] KEY_SEED = 8'h6A
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       arm,
   input  logic       wr_stb,
   input  logic [7:0] wr_data,
   output logic       hit
);
   localparam int CW = $clog2(KEY_LEN);

   if (KEY_LEN < 2) begin : g_bad_len
      $error("pnp_key_detect: KEY_LEN must be at least 2");
   end

   logic [CW-1:0] pos_q;
   logic [7:0]    want_q;
   logic          match;
   logic          at_end;

   assign match  = arm && wr_stb && (wr_data == want_q);
   assign at_end = (pos_q == CW'(KEY_LEN - 1));
   assign hit    = match && at_end;

   always_ff @(posedge clk) begin
      if (!rst_n || !arm) begin
         pos_q  <= '0;
         want_q <= KEY_SEED;
      end else if (wr_stb) begin
         if (match && !at_end) begin
            pos_q  <= pos_q + 1'b1;
            want_q <= key_step(want_q);
         end else begin
            pos_q  <= '0;
            want_q <= KEY_SEED;
         end
      end
   end
endmodule

// File: rtl/pnp_chk_unit.sv
module pnp_chk_unit
   import pnp_iso_pkg::*;
#(
   parameter int         ID_BITS   = 64,
   parameter int         CHK_BITS  = 8,
   parameter logic [7:0] CHK_SEED  = 8'h6A,
   parameter bit         CHK_CHECK = 1'b1,
   parameter int         SLOT_W    = $clog2(ID_BITS + CHK_BITS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              bit_stb,
   input  logic              bit_val,
   input  logic [SLOT_W-1:0] slot_idx,
   output logic              bad
);
   localparam int CHK_IW = $clog2(CHK_BITS);

   if (CHK_BITS != 8) begin : g_bad_chk
      $error("pnp_chk_unit: the checksum register is 8 bits");
   end

   logic [7:0]        acc_q;
   logic              bad_q;
   logic              in_id;
   logic [CHK_IW-1:0] chk_pos;

   assign in_id   = (slot_idx < SLOT_W'(ID_BITS));
   assign chk_pos = CHK_IW'(slot_idx - SLOT_W'(ID_BITS));

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         acc_q <= CHK_SEED;
         bad_q <= 1'b0;
      end else if (bit_stb) begin
         if (in_id) begin
            acc_q <= chk_step(acc_q, bit_val);
         end else if (bit_val != acc_q[chk_pos]) begin
            bad_q <= 1'b1;
         end
      end
   end

   if (CHK_CHECK) begin : g_check_on
      assign bad = bad_q;
   end else begin : g_check_off
      assign bad = 1'b0;
   end
endmodule

// File: rtl/pnp_iso_slot.sv
module pnp_iso_slot
   import pnp_iso_pkg::*;
#(
   parameter int ID_BITS  = 64,
   parameter int CHK_BITS = 8,
   parameter int SLOT_W   = $clog2(ID_BITS + CHK_BITS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              active,
   input  logic              lp_load,
   input  logic              lp_bit,
   input  logic              rd_stb,
   input  logic [7:0]        bus_in,
   output logic              need,
   output logic              drive,
   output logic [7:0]        drv_data,
   output logic              lose,
   output logic              bit_stb,
   output logic              bit_val,
   output logic [SLOT_W-1:0] slot_idx,
   output logic              done
);
   localparam int TOTAL = ID_BITS + CHK_BITS;

   logic [SLOT_W-1:0] slot_q;
   logic              second_q;
   logic              have_q;
   logic              bit_q;
   logic              seen_q;
   logic              rd_ok;

   assign done     = (slot_q == SLOT_W'(TOTAL));
   assign need     = active && !done && !have_q;
   assign rd_ok    = rd_stb && have_q && !done;
   assign drive    = rd_ok && bit_q;
   assign drv_data = second_q ? ISO_SECOND : ISO_FIRST;
   assign lose     = rd_ok && second_q && !bit_q && seen_q && (bus_in == ISO_SECOND);
   assign bit_stb  = rd_ok && second_q && !lose;
   assign bit_val  = bit_q;
   assign slot_idx = slot_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         slot_q   <= '0;
         second_q <= 1'b0;
         have_q   <= 1'b0;
         bit_q    <= 1'b0;
         seen_q   <= 1'b0;
      end else begin
         if (lp_load && need) begin
            bit_q  <= lp_bit;
            have_q <= 1'b1;
         end
         if (rd_ok) begin
            if (!second_q) begin
               second_q <= 1'b1;
               seen_q   <= !bit_q && (bus_in == ISO_FIRST);
            end else begin
               second_q <= 1'b0;
               have_q   <= 1'b0;
               seen_q   <= 1'b0;
               slot_q   <= slot_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pnp_iso_ctrl.sv
module pnp_iso_ctrl
   import pnp_iso_pkg::*;
#(
   parameter int         DATA_W    = 8,
   parameter int         ID_BITS   = 64,
   parameter int         CHK_BITS  = 8,
   parameter int         KEY_LEN   = 32,
   parameter logic [7:0] KEY_SEED  = 8'h6A,
   parameter logic [7:0] CHK_SEED  = 8'h6A,
   parameter bit         CHK_CHECK = 1'b1,
   parameter bit         IRQ_PULSE = 1'b0,
   parameter logic [7:0] REG_ISOL  = 8'h01,
   parameter logic [7:0] REG_CTRL  = 8'h02,
   parameter logic [7:0] REG_WAKE  = 8'h03,
   parameter logic [7:0] REG_CSN   = 8'h06
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_addr_wr,
   input  logic              host_data_wr,
   input  logic              host_rd,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [DATA_W-1:0] host_bus_in,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_rdrive,
   input  logic              lp_addr,
   input  logic              lp_wr,
   input  logic              lp_wbit,
   output logic [DATA_W-1:0] lp_rdata,
   output logic              lp_irq
);
   localparam int SLOT_W = $clog2(ID_BITS + CHK_BITS + 1);

   if (DATA_W != 8) begin : g_bad_dw
      $error("pnp_iso_ctrl: the host bus is 8 bits wide");
   end
   if (ID_BITS < 8 || (ID_BITS % 8) != 0) begin : g_bad_id
      $error("pnp_iso_ctrl: ID_BITS must be a nonzero multiple of 8");
   end
   if (REG_ISOL == REG_CSN || REG_WAKE == REG_CSN || REG_CTRL == REG_WAKE) begin : g_bad_map
      $error("pnp_iso_ctrl: register indices must differ");
   end

   card_state_e       state_q, state_d;
   logic [7:0]        index_q;
   logic [7:0]        csn_q, csn_d;
   logic              won_q, won_d;
   logic              ien_q;
   logic              iso_start;
   logic              key_hit;

   logic              slot_need, slot_drive, slot_lose, slot_done;
   logic              slot_bit_stb, slot_bit_val;
   logic [7:0]        slot_data;
   logic [SLOT_W-1:0] slot_idx;
   logic              chk_bad;
   logic              iso_rd;
   logic              slot_clear;

   // ---------------- unlock pattern ----------------
   pnp_key_detect #(
      .KEY_LEN (KEY_LEN),
      .KEY_SEED(KEY_SEED)
   ) u_key (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (state_q == ST_WAIT_KEY),
      .wr_stb (host_addr_wr),
      .wr_data(host_wdata),
      .hit    (key_hit)
   );

   // ---------------- contest slots ----------------
   assign iso_rd     = host_rd && (state_q == ST_ISOLATE) && (index_q == REG_ISOL);
   assign slot_clear = (state_q != ST_ISOLATE) || iso_start;

   pnp_iso_slot #(
      .ID_BITS (ID_BITS),
      .CHK_BITS(CHK_BITS),
      .SLOT_W  (SLOT_W)
   ) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (slot_clear),
      .active  (state_q == ST_ISOLATE),
      .lp_load (lp_wr && !lp_addr),
      .lp_bit  (lp_wbit),
      .rd_stb  (iso_rd),
      .bus_in  (host_bus_in),
      .need    (slot_need),
      .drive   (slot_drive),
      .drv_data(slot_data),
      .lose    (slot_lose),
      .bit_stb (slot_bit_stb),
      .bit_val (slot_bit_val),
      .slot_idx(slot_idx),
      .done    (slot_done)
   );

   pnp_chk_unit #(
      .ID_BITS  (ID_BITS),
      .CHK_BITS (CHK_BITS),
      .CHK_SEED (CHK_SEED),
      .CHK_CHECK(CHK_CHECK),
      .SLOT_W   (SLOT_W)
   ) u_chk (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (slot_clear),
      .bit_stb (slot_bit_stb),
      .bit_val (slot_bit_val),
      .slot_idx(slot_idx),
      .bad     (chk_bad)
   );

   // ---------------- card state ----------------
   always_comb begin
      state_d   = state_q;
      csn_d     = csn_q;
      won_d     = won_q;
      iso_start = 1'b0;
      if (state_q == ST_WAIT_KEY) begin
         if (key_hit) state_d = ST_SLEEP;
      end else begin
         if (host_data_wr) begin
            if (index_q == REG_CTRL && host_wdata[1]) begin
               state_d = ST_WAIT_KEY;
            end else if (index_q == REG_WAKE) begin
               if (host_wdata == csn_q) begin
                  if (csn_q == '0) begin
                     state_d   = ST_ISOLATE;
                     iso_start = 1'b1;
                  end else begin
                     state_d = ST_CONFIG;
                  end
               end else begin
                  state_d = ST_SLEEP;
               end
            end else if (index_q == REG_CSN && state_q == ST_ISOLATE && won_q &&
                         host_wdata != '0) begin
               csn_d   = host_wdata;
               state_d = ST_CONFIG;
            end
         end
         if (state_q == ST_ISOLATE && (slot_lose || (slot_done && chk_bad))) begin
            state_d = ST_SLEEP;
         end
      end
      if (state_q == ST_ISOLATE && slot_done && !chk_bad) won_d = 1'b1;
      if (state_d != ST_ISOLATE || iso_start) won_d = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_WAIT_KEY;
         csn_q   <= '0;
         won_q   <= 1'b0;
         index_q <= '0;
         ien_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         csn_q   <= csn_d;
         won_q   <= won_d;
         if (state_q == ST_WAIT_KEY) begin
            index_q <= '0;
         end else if (host_addr_wr) begin
            index_q <= host_wdata;
         end
         if (lp_wr && lp_addr) ien_q <= lp_wbit;
      end
   end

   // ---------------- host read path ----------------
   always_comb begin
      host_rdrive = 1'b0;
      host_rdata  = '0;
      if (slot_drive) begin
         host_rdrive = 1'b1;
         host_rdata  = slot_data;
      end else if (host_rd && state_q == ST_CONFIG && index_q == REG_CSN) begin
         host_rdrive = 1'b1;
         host_rdata  = csn_q;
      end
   end

   // ---------------- local processor port ----------------
   always_comb begin
      if (!lp_addr) lp_rdata = {4'b0000, state_q, won_q, slot_need};
      else          lp_rdata = csn_q;
   end

   if (IRQ_PULSE) begin : g_irq_pulse
      logic need_d;
      always_ff @(posedge clk) begin
         if (!rst_n) need_d <= 1'b0;
         else        need_d <= slot_need;
      end
      assign lp_irq = ien_q && slot_need && !need_d;
   end else begin : g_irq_level
      assign lp_irq = ien_q && slot_need;
   end
endmodule

// File: rtl/pnp_iso_ctrl_chk.sv
module pnp_iso_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] st,
   input logic [7:0] csn,
   input logic       won,
   input logic       need,
   input logic       lose,
   input logic       rdrive,
   input logic [7:0] rdata,
   input logic       irq
);
   AST_RESET_IDLE: assert property (@(posedge clk)
      !rst_n |=> (st == 2'd0 && csn == 8'h00)); // R1

   AST_KEY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (st == 2'd0) |-> !rdrive); // R10

   AST_SLOT_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
      (rdrive && st == 2'd2) |-> (rdata == 8'h55 || rdata == 8'hAA)); // R5

   AST_IRQ_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> need); // R4

   AST_NEED_IN_ISOL: assert property (@(posedge clk) disable iff (!rst_n)
      need |-> (st == 2'd2)); // R3

   AST_LOSER_SLEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      lose |=> (st == 2'd1)); // R6

   AST_WON_IN_ISOL: assert property (@(posedge clk) disable iff (!rst_n)
      won |-> (st == 2'd2)); // R7

   AST_CSN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (st != 2'd2) |=> (csn == $past(csn))); // R8
endmodule

bind pnp_iso_ctrl pnp_iso_ctrl_chk u_iso_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .st    (state_q),
   .csn   (csn_q),
   .won   (won_q),
   .need  (slot_need),
   .lose  (slot_lose),
   .rdrive(host_rdrive),
   .rdata (host_rdata),
   .irq   (lp_irq)
);

// File: tb/tb_pnp_iso_ctrl.sv
module tb_pnp_iso_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam logic [63:0] CARD_ID = 64'h3C5A_0117_8E21_F00D;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_addr_wr = 1'b0, host_data_wr = 1'b0, host_rd = 1'b0;
   logic [7:0] host_wdata = '0, host_bus_in = '0;
   logic [7:0] host_rdata;
   logic       host_rdrive;
   logic       lp_addr = 1'b0, lp_wr = 1'b0, lp_wbit = 1'b0;
   logic [7:0] lp_rdata;
   logic       lp_irq;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   bit         exp_drv_q[$];
   logic [7:0] exp_dat_q[$];
   string      exp_req_q[$];

   pnp_iso_ctrl dut (
      .clk(clk), .rst_n(rst_n),
      .host_addr_wr(host_addr_wr), .host_data_wr(host_data_wr), .host_rd(host_rd),
      .host_wdata(host_wdata), .host_bus_in(host_bus_in),
      .host_rdata(host_rdata), .host_rdrive(host_rdrive),
      .lp_addr(lp_addr), .lp_wr(lp_wr), .lp_wbit(lp_wbit),
      .lp_rdata(lp_rdata), .lp_irq(lp_irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [7:0] key_byte(input int n);
      logic [7:0] k = 8'h6A;
      for (int i = 0; i < n; i++) k = {k[6:0], k[7] ^ k[5] ^ k[4] ^ k[3]};
      return k;
   endfunction

   function automatic logic [7:0] id_sum(input logic [63:0] id);
      logic [7:0] c = 8'h6A;
      for (int i = 0; i < 64; i++) c = {c[0] ^ c[1] ^ id[i], c[7:1]};
      return c;
   endfunction

   task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic host_addr(input logic [7:0] v);
      tick(); host_addr_wr = 1'b1; host_wdata = v;
      tick(); host_addr_wr = 1'b0;
   endtask

   task automatic reg_write(input logic [7:0] idx, input logic [7:0] v);
      host_addr(idx);
      tick(); host_data_wr = 1'b1; host_wdata = v;
      tick(); host_data_wr = 1'b0;
   endtask

   // driver: pushes the expected bus result for one read
   task automatic host_read(input bit drv, input logic [7:0] dat, input string req,
                            input logic [7:0] bus);
      exp_drv_q.push_back(drv); exp_dat_q.push_back(dat); exp_req_q.push_back(req);
      tick(); host_rd = 1'b1; host_bus_in = bus;
      tick(); host_rd = 1'b0; host_bus_in = 8'h00;
   endtask

   task automatic lp_write(input logic a, input logic b);
      tick(); lp_wr = 1'b1; lp_addr = a; lp_wbit = b;
      tick(); lp_wr = 1'b0; lp_addr = 1'b0;
   endtask

   task automatic lp_check(input logic a, input logic [7:0] exp, input string req);
      tick(); lp_addr = a;
      @(negedge clk);
      check8(req, lp_rdata, exp);
      lp_addr = 1'b0;
   endtask

   task automatic irq_check(input logic exp, input string req);
      @(negedge clk);
      check8(req, {7'b0, lp_irq}, {7'b0, exp});
   endtask

   task automatic send_key(input int bad_at);
      for (int i = 0; i < 32; i++)
         host_addr(i == bad_at ? ~key_byte(i) : key_byte(i));
   endtask

   task automatic wait_need(input string req);
      bit seen = 1'b0;
      for (int i = 0; i < 40 && !seen; i++) begin
         @(negedge clk);
         if (lp_addr == 1'b0 && lp_rdata[0]) seen = 1'b1;
      end
      if (!seen) begin
         checks++; fails++;
         $display("FAIL %s actual=need_low expected=need_high", req);
      end
   endtask

   task automatic run_slot(input logic b, input logic [7:0] bus0, input logic [7:0] bus1,
                           input string req);
      wait_need(req);
      lp_write(1'b0, b);
      host_read(b, 8'h55, req, bus0);
      host_read(b, 8'hAA, req, bus1);
   endtask

   task automatic do_reset();
      tick(); rst_n = 1'b0;
      repeat (4) tick();
      rst_n = 1'b1;
   endtask

   // monitor: compares each read with the head of the scoreboard
   always @(negedge clk) begin
      if (rst_n && host_rd) begin
         checks++;
         if (exp_drv_q.size() == 0) begin
            fails++;
            $display("FAIL unexpected read actual=%0b/%02h expected=none", host_rdrive, host_rdata);
         end else begin
            automatic bit         ed = exp_drv_q.pop_front();
            automatic logic [7:0] ev = exp_dat_q.pop_front();
            automatic string      er = exp_req_q.pop_front();
            if (host_rdrive !== ed || (ed && host_rdata !== ev)) begin
               fails++;
               $display("FAIL %s read actual=%0b/%02h expected=%0b/%02h",
                        er, host_rdrive, host_rdata, ed, ev);
            end
         end
      end
   end

   initial begin
      logic [7:0] good_sum;
      logic [7:0] bad_sum;
      good_sum = id_sum(CARD_ID);
      bad_sum  = good_sum ^ 8'h01;
      repeat (4) tick();
      rst_n = 1'b1;

      // R1 reset state
      lp_check(1'b0, 8'h00, "R1");
      lp_check(1'b1, 8'h00, "R1");
      irq_check(1'b0, "R1");
      host_read(1'b0, 8'h00, "R1", 8'h00);

      // R10 wait-for-key ignores data writes
      reg_write(8'h03, 8'h00);
      lp_check(1'b0, 8'h00, "R10");

      // R2 broken pattern, then a clean one
      send_key(10);
      lp_check(1'b0, 8'h00, "R2");
      send_key(-1);
      lp_check(1'b0, 8'h04, "R2");

      // R3 wake with wrong value stays asleep
      reg_write(8'h03, 8'h05);
      lp_check(1'b0, 8'h04, "R3");

      // R3/R4 isolation entry with interrupt enabled
      lp_write(1'b1, 1'b1);
      reg_write(8'h03, 8'h00);
      lp_check(1'b0, 8'h09, "R3");
      irq_check(1'b1, "R4");

      // R5 early read is left unanswered and the slot holds
      host_addr(8'h01);
      host_read(1'b0, 8'h00, "R5", 8'h00);
      lp_check(1'b0, 8'h09, "R5");

      // slot 0 by hand: need and interrupt clear when the bit arrives (R4)
      lp_write(1'b0, CARD_ID[0]);
      irq_check(1'b0, "R4");
      lp_check(1'b0, 8'h08, "R4");
      host_read(CARD_ID[0], 8'h55, "R5", 8'h00);
      host_read(CARD_ID[0], 8'hAA, "R5", 8'h00);

      for (int i = 1; i < 64; i++) run_slot(CARD_ID[i], 8'h00, 8'h00, "R5");
      for (int i = 0; i < 8; i++)  run_slot(good_sum[i], 8'h00, 8'h00, "R7");
      lp_check(1'b0, 8'h0A, "R7");

      // R8 number assignment
      reg_write(8'h06, 8'h01);
      lp_check(1'b0, 8'h0C, "R8");
      lp_check(1'b1, 8'h01, "R8");
      host_read(1'b1, 8'h01, "R8", 8'h00);

      // R10 back to wait-for-key, number kept, reads quiet
      reg_write(8'h02, 8'h02);
      lp_check(1'b0, 8'h00, "R10");
      lp_check(1'b1, 8'h01, "R10");
      host_read(1'b0, 8'h00, "R10", 8'h00);

      // R9 numbered card ignores the contest wake
      send_key(-1);
      reg_write(8'h03, 8'h00);
      lp_check(1'b0, 8'h04, "R9");
      irq_check(1'b0, "R9");

      // R11 direct wake by number
      reg_write(8'h03, 8'h01);
      lp_check(1'b0, 8'h0C, "R11");
      host_addr(8'h06);
      host_read(1'b1, 8'h01, "R11", 8'h00);

      // R6 drop-out against a competing one bit
      do_reset();
      send_key(-1);
      reg_write(8'h03, 8'h00);
      host_addr(8'h01);
      run_slot(1'b0, 8'h55, 8'hAA, "R6");
      lp_check(1'b0, 8'h04, "R6");
      host_read(1'b0, 8'h00, "R6", 8'h00);

      // R7 checksum mismatch; slot 1 also shows a partial pattern does not drop (R6)
      do_reset();
      send_key(-1);
      reg_write(8'h03, 8'h00);
      host_addr(8'h01);
      run_slot(CARD_ID[0], 8'h00, 8'h00, "R5");
      run_slot(CARD_ID[1], 8'h55, 8'h00, "R6");
      lp_check(1'b0, 8'h09, "R6");
      for (int i = 2; i < 64; i++) run_slot(CARD_ID[i], 8'h00, 8'h00, "R5");
      for (int i = 0; i < 8; i++)  run_slot(bad_sum[i], 8'h00, 8'h00, "R7");
      lp_check(1'b0, 8'h04, "R7");
      host_read(1'b0, 8'h00, "R7", 8'h00);

      repeat (3) tick();
      checks++;
      if (exp_drv_q.size() != 0) begin
         fails++;
         $display("FAIL scoreboard actual=%0d expected=0 pending reads", exp_drv_q.size());
      end
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule